// File: doc/BRIEF.md
# Cross-Bank State Merger with Double-Buffered Frame Store

This block sits behind the column bank scanners of a pixel sensor readout. On every row period the scanners present, per bank, up to six state words (a column address within the bank and a two-bit run code) plus a count of how many are valid. The block gathers these across all eighteen banks into one ordered list. It keeps at most nine states per row and tags each kept state with its bank number. Every row that has hits is prefixed with a header word that carries the row index, the kept count and an overflow flag.

The merged words go into one of two frame buffers, both modelled as register arrays. A frame-start pulse closes the buffer being filled and opens the other. Closing writes a word count near the front of the buffer and a trailer at its end. The closed frame is then shifted out serially, MSB first, while the next frame is being written. The receiver sees a data bit, a bit-valid enable and a marker on the first bit of each frame.

Top module: `state_merge_store`

## Requirements
- R1: After reset, ser_data, ser_en and ser_frame are low. The first frame-start only opens a frame, so no serial output appears until a second frame-start closes it.
- R2: Kept states are ordered by ascending bank, and within a bank by input slot. At most 9 states are kept per row; later ones are discarded. A state word is kind 2'b10 in bits [17:16].
- R3: A row with at least one valid state writes a header word before its states. The header is {2'b01, ovf, kept[3:0], 1'b0, row[9:0]}, where kept is the number of states kept (at most 9), and ovf is set exactly when the row offered more than 9 states.
- R4: A bank count above 6 is treated as 6. Bank b's count is bank_cnt[3b+2:3b].
- R5: A row whose banks all report zero states writes no word at all.
- R6: A state word is {2'b10, 3'b000, bank[4:0], col[5:0], code[1:0]}. Slot j of bank b is read from bank_state[8(6b+j)+7 : 8(6b+j)], with the column in the upper six bits and the code in the lower two.
- R7: A frame is laid out as: a header {2'b11, 2'b00, frame_no[13:0]} (frame numbers count 0, 1, 2 from the first opened frame), then a count word {2'b00, total[15:0]} giving the number of words including header, count and trailer, then the rows, then the trailer.
- R8: A row is written only if its header, its states and the trailer all still fit in BUF_DEPTH words. Otherwise the whole row is dropped and the trailer {2'b11, 1'b1, trunc, frame_no[13:0]} has trunc set.
- R9: After the frame-start that closes a frame, that frame is shifted out MSB first. ser_frame is high exactly on the first bit of its header word.
- R10: A frame's bits are contiguous: ser_en stays high for exactly total*18 consecutive cycles.
- R11: While ser_en is low, ser_data and ser_frame are low.
- R12: A row presented in the same cycle as a frame-start belongs to the newly opened frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_valid | input | 1 | One-cycle strobe: bank data for a row is valid |
| row_idx | input | 10 | Row index of the presented row |
| bank_cnt | input | 54 | Per-bank valid state count, 3 bits per bank |
| bank_state | input | 864 | Per-bank state slots, 8 bits each, 6 per bank |
| frame_start | input | 1 | One-cycle strobe: close the current frame, open the next |
| ser_data | output | 1 | Serial data bit |
| ser_en | output | 1 | High when ser_data carries a frame bit |
| ser_frame | output | 1 | High on the first bit of a frame |

## Verification
The bench builds the block with BUF_DEPTH set to 24 words and leaves the bank, slot and keep limits at their defaults. With only 24 words, two full rows nearly fill a buffer, so dropping a whole row and setting the trailer flag can be reached with a few directed rows. The default depth of 256 would need dozens of rows to get there. Keeping 18 banks of 6 slots makes the cut at the ninth state fall inside the second bank. A row with every bank full therefore tests both the ordering and the overflow flag.

// File: rtl/zsm_pkg.sv
package zsm_pkg;
    localparam int N_BANKS    = 18;
    localparam int N_PER_BANK = 6;
    localparam int M_KEEP     = 9;
    localparam int COL_W      = 6;
    localparam int CODE_W     = 2;
    localparam int ROW_W      = 10;
    localparam int WORD_W     = 18;

    localparam int BANK_W    = $clog2(N_BANKS);
    localparam int CNT_W     = $clog2(N_PER_BANK + 1);
    localparam int KEEP_W    = $clog2(M_KEEP + 1);
    localparam int STW       = COL_W + CODE_W;
    localparam int TOT_W     = $clog2(N_BANKS * N_PER_BANK + 1);
    localparam int PAYLOAD_W = WORD_W - 2;
    localparam int ROWF_W    = PAYLOAD_W - 1 - KEEP_W;
    localparam int FN_W      = PAYLOAD_W - 2;
    localparam int STF_W     = BANK_W + STW;

    typedef enum logic [1:0] {
        WK_COUNT = 2'b00,
        WK_ROW   = 2'b01,
        WK_STATE = 2'b10,
        WK_FRAME = 2'b11
    } word_kind_e;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
        logic [CODE_W-1:0] code;
    } kept_t;

    typedef struct packed {
        logic [ROW_W-1:0]       row;
        logic                   ovf;
        logic [KEEP_W-1:0]      cnt;
        kept_t [M_KEEP-1:0]     st;
    } row_rec_t;

    function automatic logic [WORD_W-1:0] mk_state(input kept_t k);
        return {WK_STATE, PAYLOAD_W'(k)};
    endfunction

    function automatic logic [WORD_W-1:0] mk_row_hdr(input row_rec_t r);
        return {WK_ROW, r.ovf, r.cnt, ROWF_W'(r.row)};
    endfunction

    function automatic logic [WORD_W-1:0] mk_frame_hdr(input logic [FN_W-1:0] fn);
        return {WK_FRAME, 2'b00, fn};
    endfunction

    function automatic logic [WORD_W-1:0] mk_trailer(input logic [FN_W-1:0] fn,
                                                      input logic trunc);
        return {WK_FRAME, 1'b1, trunc, fn};
    endfunction

    function automatic logic [WORD_W-1:0] mk_count(input logic [PAYLOAD_W-1:0] n);
        return {WK_COUNT, n};
    endfunction
endpackage

// File: rtl/zsm_merge.sv
module zsm_merge
    import zsm_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              row_valid,
    input  logic [ROW_W-1:0]                  row_idx,
    input  logic [N_BANKS*CNT_W-1:0]          bank_cnt,
    input  logic [N_BANKS*N_PER_BANK*STW-1:0] bank_state,
    output logic                              rec_valid,
    output row_rec_t                          rec
);
    logic [CNT_W-1:0] clamp_cnt [N_BANKS];
    logic [TOT_W-1:0] base      [N_BANKS];
    logic [TOT_W-1:0] total;
    row_rec_t         nxt;

    // per-bank count clamp to the slot limit
    for (genvar b = 0; b < N_BANKS; b++) begin : g_clamp
        logic [CNT_W-1:0] raw;
        assign raw = bank_cnt[b*CNT_W +: CNT_W];
        assign clamp_cnt[b] = (raw > CNT_W'(N_PER_BANK)) ? CNT_W'(N_PER_BANK) : raw;
    end

    always_comb begin
        total = '0;
        for (int b = 0; b < N_BANKS; b++) begin
            base[b] = total;
            total   = total + TOT_W'(clamp_cnt[b]);
        end
    end

    // global index of slot j in bank b is base[b]+j; output slot k takes index k
    always_comb begin
        nxt     = '0;
        nxt.row = row_idx;
        for (int k = 0; k < M_KEEP; k++) begin
            for (int b = 0; b < N_BANKS; b++) begin
                for (int j = 0; j < N_PER_BANK; j++) begin
                    if ((TOT_W'(j) < TOT_W'(clamp_cnt[b])) &&
                        (base[b] + TOT_W'(j) == TOT_W'(k))) begin
                        nxt.st[k].bank = BANK_W'(b);
                        nxt.st[k].col  = bank_state[(b*N_PER_BANK+j)*STW + CODE_W +: COL_W];
                        nxt.st[k].code = bank_state[(b*N_PER_BANK+j)*STW +: CODE_W];
                    end
                end
            end
        end
        nxt.ovf = (total > TOT_W'(M_KEEP));
        nxt.cnt = nxt.ovf ? KEEP_W'(M_KEEP) : KEEP_W'(total);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_valid <= 1'b0;
            rec       <= '0;
        end else begin
            rec_valid <= row_valid;
            if (row_valid) rec <= nxt;
        end
    end

    // an overflowing row must have filled every kept slot
    assert_ovf_full_R3: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec.ovf) |-> (rec.cnt == KEEP_W'(M_KEEP)));
endmodule

// File: rtl/zsm_frame_store.sv
module zsm_frame_store
    import zsm_pkg::*;
#(
    parameter int BUF_DEPTH = 256
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                frame_start,
    input  logic                rec_valid,
    input  row_rec_t            rec,
    input  logic [$clog2(BUF_DEPTH)-1:0]   rd_addr,
    output logic [WORD_W-1:0]              rd_word,
    output logic                           launch,
    output logic [$clog2(BUF_DEPTH+1)-1:0] launch_len
);
    localparam int ADDR_W = $clog2(BUF_DEPTH);
    localparam int PTR_W  = $clog2(BUF_DEPTH + 1);

    logic [WORD_W-1:0] mem [2][BUF_DEPTH];
    logic              open_q, wbuf, rbuf, busy, trunc;
    logic [ADDR_W-1:0] wptr;
    logic [KEEP_W-1:0] idx;
    logic [FN_W-1:0]   fnum;
    logic              row_fits;

    assign row_fits = open_q && (rec.cnt != '0) &&
                      (int'(wptr) + int'(rec.cnt) + 2 <= BUF_DEPTH);

    assign rd_word = mem[rbuf][rd_addr];

    // buffer contents: no reset
    always_ff @(posedge clk) begin
        if (!rst) begin
            if (frame_start) begin
                if (open_q) begin
                    mem[wbuf][1]     <= mk_count(PAYLOAD_W'(wptr) + PAYLOAD_W'(1));
                    mem[wbuf][wptr]  <= mk_trailer(fnum, trunc);
                    mem[~wbuf][0]    <= mk_frame_hdr(fnum + FN_W'(1));
                end else begin
                    mem[wbuf][0]     <= mk_frame_hdr(fnum);
                end
            end else if (rec_valid) begin
                if (row_fits) mem[wbuf][wptr] <= mk_row_hdr(rec);
            end else if (busy) begin
                mem[wbuf][wptr] <= mk_state(rec.st[idx]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q     <= 1'b0;
            wbuf       <= 1'b0;
            rbuf       <= 1'b0;
            busy       <= 1'b0;
            trunc      <= 1'b0;
            wptr       <= '0;
            idx        <= '0;
            fnum       <= '0;
            launch     <= 1'b0;
            launch_len <= '0;
        end else begin
            launch <= 1'b0;
            if (frame_start) begin
                if (open_q) begin
                    launch     <= 1'b1;
                    launch_len <= PTR_W'(wptr) + PTR_W'(1);
                    rbuf       <= wbuf;
                    wbuf       <= ~wbuf;
                    fnum       <= fnum + FN_W'(1);
                end
                open_q <= 1'b1;
                wptr   <= ADDR_W'(2);
                trunc  <= 1'b0;
                busy   <= 1'b0;
            end else if (rec_valid) begin
                if (row_fits) begin
                    wptr <= wptr + ADDR_W'(1);
                    busy <= 1'b1;
                    idx  <= '0;
                end else if (open_q && rec.cnt != '0) begin
                    trunc <= 1'b1;
                end
            end else if (busy) begin
                wptr <= wptr + ADDR_W'(1);
                idx  <= idx + KEEP_W'(1);
                if (idx == rec.cnt - KEEP_W'(1)) busy <= 1'b0;
            end
        end
    end

    // rows must be spaced so the previous row has drained
    assert_row_gap_R2: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> !busy);
    // a frame boundary may not cut a row in half
    assert_start_idle_R12: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (!busy && !rec_valid));
    // while states are written a slot stays free for the trailer
    assert_trailer_room_R8: assert property (@(posedge clk) disable iff (rst)
        busy |-> (int'(wptr) <= BUF_DEPTH - 2));
endmodule

// File: rtl/zsm_serializer.sv
module zsm_serializer
    import zsm_pkg::*;
#(
    parameter int BUF_DEPTH = 256
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           launch,
    input  logic [$clog2(BUF_DEPTH+1)-1:0] launch_len,
    output logic [$clog2(BUF_DEPTH)-1:0]   rd_addr,
    input  logic [WORD_W-1:0]              rd_word,
    output logic                           ser_data,
    output logic                           ser_en,
    output logic                           ser_frame
);
    localparam int ADDR_W = $clog2(BUF_DEPTH);
    localparam int PTR_W  = $clog2(BUF_DEPTH + 1);
    localparam int BIT_W  = $clog2(WORD_W);

    logic              active;
    logic [ADDR_W-1:0] ridx;
    logic [BIT_W-1:0]  bpos;
    logic [PTR_W-1:0]  len_q;
    logic              last_bit, last_word;

    assign rd_addr   = ridx;
    assign last_bit  = (bpos == BIT_W'(WORD_W - 1));
    assign last_word = (PTR_W'(ridx) + PTR_W'(1) == len_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            ridx      <= '0;
            bpos      <= '0;
            len_q     <= '0;
            ser_data  <= 1'b0;
            ser_en    <= 1'b0;
            ser_frame <= 1'b0;
        end else begin
            if (active) begin
                ser_data  <= rd_word[BIT_W'(WORD_W - 1) - bpos];
                ser_en    <= 1'b1;
                ser_frame <= (ridx == '0) && (bpos == '0);
                if (last_bit) begin
                    bpos <= '0;
                    ridx <= ridx + ADDR_W'(1);
                    if (last_word) active <= 1'b0;
                end else begin
                    bpos <= bpos + BIT_W'(1);
                end
            end else begin
                ser_data  <= 1'b0;
                ser_en    <= 1'b0;
                ser_frame <= 1'b0;
            end
            if (launch) begin
                active <= 1'b1;
                ridx   <= '0;
                bpos   <= '0;
                len_q  <= launch_len;
            end
        end
    end

    // a new frame may not arrive while the previous one is still shifting
    assert_no_overlap_R10: assert property (@(posedge clk) disable iff (rst)
        launch |-> !active);
    // every closed frame holds at least header, count and trailer
    assert_len_min_R7: assert property (@(posedge clk) disable iff (rst)
        launch |-> (launch_len >= PTR_W'(3)));
endmodule

// File: rtl/state_merge_store.sv
module state_merge_store
    import zsm_pkg::*;
#(
    parameter int BUF_DEPTH = 256
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              row_valid,
    input  logic [ROW_W-1:0]                  row_idx,
    input  logic [N_BANKS*CNT_W-1:0]          bank_cnt,
    input  logic [N_BANKS*N_PER_BANK*STW-1:0] bank_state,
    input  logic                              frame_start,
    output logic                              ser_data,
    output logic                              ser_en,
    output logic                              ser_frame
);
    localparam int ADDR_W = $clog2(BUF_DEPTH);
    localparam int PTR_W  = $clog2(BUF_DEPTH + 1);

    logic              rec_valid;
    row_rec_t          rec;
    logic [ADDR_W-1:0] rd_addr;
    logic [WORD_W-1:0] rd_word;
    logic              launch;
    logic [PTR_W-1:0]  launch_len;

    zsm_merge u_merge (
        .clk        (clk),
        .rst        (rst),
        .row_valid  (row_valid),
        .row_idx    (row_idx),
        .bank_cnt   (bank_cnt),
        .bank_state (bank_state),
        .rec_valid  (rec_valid),
        .rec        (rec)
    );

    zsm_frame_store #(.BUF_DEPTH(BUF_DEPTH)) u_store (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .rec_valid   (rec_valid),
        .rec         (rec),
        .rd_addr     (rd_addr),
        .rd_word     (rd_word),
        .launch      (launch),
        .launch_len  (launch_len)
    );

    zsm_serializer #(.BUF_DEPTH(BUF_DEPTH)) u_ser (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .launch_len (launch_len),
        .rd_addr    (rd_addr),
        .rd_word    (rd_word),
        .ser_data   (ser_data),
        .ser_en     (ser_en),
        .ser_frame  (ser_frame)
    );
endmodule

// File: tb/sim_state_merge_store.sv
module sim_state_merge_store;
    import zsm_pkg::*;

    localparam int D  = 24;
    localparam int WW = 18;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic row_valid = 1'b0;
    logic frame_start = 1'b0;
    logic [ROW_W-1:0] row_idx = '0;
    logic [N_BANKS*CNT_W-1:0] bank_cnt = '0;
    logic [N_BANKS*N_PER_BANK*STW-1:0] bank_state = '0;
    logic ser_data, ser_en, ser_frame;

    always #2 clk = ~clk;

    state_merge_store #(.BUF_DEPTH(D)) u0 (
        .clk(clk), .rst(rst), .row_valid(row_valid), .row_idx(row_idx),
        .bank_cnt(bank_cnt), .bank_state(bank_state), .frame_start(frame_start),
        .ser_data(ser_data), .ser_en(ser_en), .ser_frame(ser_frame)
    );

    int checks = 0, errors = 0;
    int mon_checks = 0, mon_errors = 0;
    bit done = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // stimulus description of one row
    int rc [N_BANKS];
    int rcol [N_BANKS][N_PER_BANK];
    int rcode [N_BANKS][N_PER_BANK];

    // model state
    logic [WW-1:0] exp_q[$];
    string         exp_tag[$];
    logic [WW-1:0] cur[$];
    string         cur_tag[$];
    string         pend_tag = "";
    bit            fopen = 0;
    bit            ftrunc = 0;
    int            fno = -1;

    // monitor state
    logic [WW-1:0] cap_q[$];
    bit            cap_mark[$];
    logic [WW-1:0] shreg = '0;
    int            bpos = 0;
    bit            mark_pend = 0;
    int            run = 0;
    int            wcnt = 0;
    int            fr_total = 0;
    bit            prev_en = 0;
    int            idle_bad = 0;
    int            en_seen = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    function automatic void push_w(input logic [WW-1:0] w, input string tag);
        cur.push_back(w);
        if (pend_tag != "") begin
            cur_tag.push_back(pend_tag);
            pend_tag = "";
        end else begin
            cur_tag.push_back(tag);
        end
    endfunction

    function automatic void model_row(input int row, input string tag);
        logic [WW-1:0] sw[$];
        int total = 0;
        for (int b = 0; b < N_BANKS; b++) begin
            int c = (rc[b] > 6) ? 6 : rc[b];
            for (int j = 0; j < c; j++) begin
                total++;
                if (sw.size() < 9)
                    sw.push_back({2'b10, 3'b000, 5'(b), 6'(rcol[b][j]), 2'(rcode[b][j])});
            end
        end
        if (!fopen) return;
        if (sw.size() == 0) begin
            if (tag == "R5") pend_tag = "R5";
            return;
        end
        if (cur.size() + sw.size() + 2 <= D) begin
            push_w({2'b01, (total > 9) ? 1'b1 : 1'b0, 4'(sw.size()), 1'b0, 10'(row)}, tag);
            foreach (sw[i]) push_w(sw[i], tag);
        end else begin
            ftrunc = 1;
        end
    endfunction

    function automatic void model_start();
        if (fopen) begin
            cur[1] = {2'b00, 16'(cur.size() + 1)};
            cur.push_back({2'b11, 1'b1, ftrunc, 14'(fno)});
            cur_tag.push_back(ftrunc ? "R8" : "R7");
            foreach (cur[i]) begin
                exp_q.push_back(cur[i]);
                exp_tag.push_back(cur_tag[i]);
            end
        end
        fno++;
        fopen  = 1;
        ftrunc = 0;
        cur.delete();
        cur_tag.delete();
        cur.push_back({2'b11, 2'b00, 14'(fno)});
        cur_tag.push_back("R7");
        cur.push_back('0);
        cur_tag.push_back("R7");
    endfunction

    task automatic apply_row();
        for (int b = 0; b < N_BANKS; b++) begin
            bank_cnt[b*CNT_W +: CNT_W] = 3'(rc[b]);
            for (int j = 0; j < N_PER_BANK; j++)
                bank_state[(b*N_PER_BANK+j)*STW +: STW] = {6'(rcol[b][j]), 2'(rcode[b][j])};
        end
    endtask

    task automatic clear_row();
        for (int b = 0; b < N_BANKS; b++) begin
            rc[b] = 0;
            for (int j = 0; j < N_PER_BANK; j++) begin
                rcol[b][j]  = $urandom % 64;
                rcode[b][j] = $urandom % 4;
            end
        end
    endtask

    task automatic drive_row(input int row, input string tag);
        @(negedge clk);
        apply_row();
        row_idx   = 10'(row);
        row_valid = 1'b1;
        model_row(row, tag);
        @(negedge clk);
        row_valid = 1'b0;
        repeat (11) @(negedge clk);
    endtask

    int fstart_cyc = 0;
    task automatic start_frame(input bit with_row, input int row, input string tag);
        if (fopen) begin
            while (cyc < fstart_cyc + 470) @(negedge clk);
        end
        @(negedge clk);
        fstart_cyc  = cyc;
        frame_start = 1'b1;
        model_start();
        if (with_row) begin
            apply_row();
            row_idx   = 10'(row);
            row_valid = 1'b1;
            model_row(row, tag);
        end
        @(negedge clk);
        frame_start = 1'b0;
        row_valid   = 1'b0;
        repeat (11) @(negedge clk);
    endtask

    task automatic random_rows(input int n);
        for (int r = 0; r < n; r++) begin
            clear_row();
            for (int b = 0; b < N_BANKS; b++)
                if ($urandom % 5 == 0) rc[b] = $urandom % 8;
            drive_row($urandom % 576, "R6");
        end
    endtask

    // serial monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (!ser_en && (ser_data || ser_frame)) idle_bad++;
            if (ser_en) begin
                en_seen++;
                if (ser_frame) begin
                    mon_checks++;
                    if (bpos != 0) begin
                        mon_errors++;
                        $display("FAIL R9 frame marker off word boundary actual=%0d expected=0", bpos);
                    end
                    run = 0;
                    wcnt = 0;
                    mark_pend = 1;
                end
                run++;
                shreg = {shreg[WW-2:0], ser_data};
                bpos++;
                if (bpos == WW) begin
                    cap_q.push_back(shreg);
                    cap_mark.push_back(mark_pend);
                    mark_pend = 0;
                    bpos = 0;
                    wcnt++;
                    if (wcnt == 2) fr_total = int'(shreg[15:0]);
                end
            end
            if (prev_en && !ser_en) begin
                mon_checks++;
                if (run != fr_total * WW) begin
                    mon_errors++;
                    $display("FAIL R10 enable run actual=%0d expected=%0d", run, fr_total * WW);
                end
            end
            prev_en = ser_en;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        clear_row();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(!ser_en && !ser_data && !ser_frame, "R1", "outputs after reset",
            {29'd0, ser_en, ser_data, ser_frame}, 0);

        // frame 0: ordering, empty row, clamp
        start_frame(0, 0, "");
        clear_row(); rc[3] = 2; rc[0] = 1;
        drive_row(5, "R2");
        clear_row();
        drive_row(6, "R5");
        clear_row(); rc[2] = 7; rc[11] = 1;
        drive_row(7, "R4");
        while (cyc < fstart_cyc + 470) @(negedge clk);
        // R1: nothing shifted before the first frame is closed
        chk(en_seen == 0, "R1", "serial activity in first frame", en_seen, 0);

        // frame 1: overflow boundaries
        start_frame(0, 0, "");
        clear_row(); for (int b = 0; b < N_BANKS; b++) rc[b] = 6;
        drive_row(100, "R3");
        clear_row(); rc[0] = 5; rc[1] = 4;
        drive_row(101, "R3");
        clear_row(); rc[0] = 5; rc[1] = 4; rc[17] = 1;
        drive_row(102, "R3");

        // frame 2: row together with frame start
        clear_row(); rc[9] = 3;
        start_frame(1, 200, "R12");
        random_rows(3);

        // frame 3: truncation
        start_frame(0, 0, "");
        for (int r = 0; r < 3; r++) begin
            clear_row(); rc[4] = 6; rc[5] = 3;
            drive_row(300 + r, "R8");
        end
        clear_row(); rc[0] = 1;
        drive_row(310, "R8");

        // random frames
        for (int f = 0; f < 6; f++) begin
            start_frame(0, 0, "");
            random_rows(1 + ($urandom % 5));
        end
        start_frame(0, 0, "");
        repeat (500) @(negedge clk);

        chk(cap_q.size() == exp_q.size(), "R7", "captured word count",
            cap_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < cap_q.size(); i++) begin
            bit m_exp;
            m_exp = (exp_q[i][17:16] == 2'b11) && !exp_q[i][15];
            chk(cap_q[i] == exp_q[i], exp_tag[i], $sformatf("word %0d", i),
                32'(cap_q[i]), 32'(exp_q[i]));
            chk(cap_mark[i] == m_exp, "R9", $sformatf("marker at word %0d", i),
                32'(cap_mark[i]), 32'(m_exp));
        end
        chk(idle_bad == 0, "R11", "idle cycles with data or marker", idle_bad, 0);
        checks += mon_checks;
        errors += mon_errors;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks + mon_checks, errors + mon_errors);
            $finish;
        end
    end
endmodule